// File: doc/BRIEF.md
# Adaptive Iteration and Early-Stop Controller for an LDPC Decoder

This block sequences the iteration loop of an iterative LDPC decoder. After a frame start it walks the decoder through one initialisation step. It then runs repeated iterations, each made of a check-node phase followed by a bit-node phase. Each phase is launched by a one-cycle enable and closed by a one-cycle done pulse from the datapath. The message-passing datapath itself lives outside this block.

The hard-decision and syndrome stages are costly, and they cannot succeed while the channel is too noisy for the code to have converged. The controller therefore holds them off for a number of early iterations chosen from an SNR index. Decoding ends with success when the syndrome stage reports an all-zero syndrome. It ends without success when the iteration cap, supplied by the voltage/frequency selector and clamped to a hard limit, is used up. A single-cycle done pulse marks the end of decoding. The iteration count and the success flag are held afterwards for the consumer.

Top module: `ldpc_iter_ctrl`

## Requirements
- R1: While and right after reset, every phase enable, `dec_done` and `dec_ok` are 0 and `iter_count` is 0.
- R2: A `frame_start` seen while idle raises `init_en` in the next cycle. After that the phases follow a fixed order: init, check-node, bit-node, then either tentative and parity or the next check-node. Each enable is high for one cycle, at most one enable is high at a time, and each later enable rises in the cycle after the done pulse of the phase before it.
- R3: The first iteration whose end runs the tentative and parity phases is taken from `snr_idx`, an unsigned index in half-dB steps (index = 2 × SNR in dB, negative SNR coded as 0). The iteration is 50 for index 0–1, 42 for 2, 10 for 3, 6 for 4, 4 for 5–7, 3 for 8, 2 for 9–12, and 1 for 13 and above. Earlier iterations issue no `td_en` and no `pc_en`, and every later iteration issues both.
- R4: If `syndrome_zero` is 1 in the cycle of `pc_done`, decoding ends. `dec_ok` is then 1 and `iter_count` equals the number of check-node phases run in the frame.
- R5: If the cap is reached without success, decoding ends after that iteration's last phase with `dec_ok` 0 and `iter_count` equal to the effective cap.
- R6: The effective cap is `cap_in` limited to 50, and a `cap_in` of 0 counts as 1. The values of `snr_idx` and `cap_in` are taken at the accepted frame start.
- R7: `dec_done` is high for exactly one cycle. `iter_count` and `dec_ok` then hold until the next accepted frame start.
- R8: A `frame_start` that arrives while decoding is in progress has no effect. No new `init_en` appears, and the running frame finishes with its original settings.
- R9: When the first checked iteration lies beyond the effective cap, no tentative or parity phase runs. The frame ends at the cap with `dec_ok` 0.

Top module parameters: `MAX_ITER` (hard iteration limit, default 50), `SNR_W` (default 5), `CAP_W` (default 6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_start | input | 1 | Start of a new frame (honoured only when idle) |
| snr_idx | input | SNR_W | SNR index in half-dB steps |
| cap_in | input | CAP_W | Requested iteration cap |
| init_done | input | 1 | Initialisation phase finished |
| cn_done | input | 1 | Check-node phase finished |
| bn_done | input | 1 | Bit-node phase finished |
| td_done | input | 1 | Tentative-decision phase finished |
| pc_done | input | 1 | Parity-check phase finished |
| syndrome_zero | input | 1 | Syndrome is all zero, valid with pc_done |
| init_en | output | 1 | Start initialisation |
| cn_en | output | 1 | Start check-node phase |
| bn_en | output | 1 | Start bit-node phase |
| td_en | output | 1 | Start tentative-decision phase |
| pc_en | output | 1 | Start parity-check phase |
| dec_done | output | 1 | One-cycle end-of-decoding pulse |
| dec_ok | output | 1 | Last frame decoded successfully |
| iter_count | output | $clog2(MAX_ITER+1) | Iterations run in the last or current frame |

## Verification
The hardest cases to reach are the ones where the SNR-driven gate and the cap interact: a first checked iteration beyond a small cap, and the hard limit hit from an oversized or zero cap. The bench reaches them by choosing the SNR index, the cap and the iteration at which its emulated datapath reports a zero syndrome, so that each end path is taken on purpose. It also reaches a frame start that lands in the middle of a long frame. For that case it picks a low SNR index, so the frame is still in its early, unchecked iterations when the stray start arrives, with new settings on the inputs.

// File: rtl/ldpc_ctrl_pkg.sv
// Shared types for the LDPC iteration controller.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package ldpc_ctrl_pkg;

    // Phase the controller is currently waiting on.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_INIT,
        PH_CN,
        PH_BN,
        PH_TD,
        PH_PC
    } phase_e;

endpackage

// File: rtl/ldpc_snr_gate.sv
// Maps the half-dB SNR index to the first iteration that runs the
// tentative decision and the syndrome check.
// Assumes MAX_ITER fits in ITER_W bits and is at least 42.
module ldpc_snr_gate #(
    parameter int SNR_W    = 5,
    parameter int ITER_W   = 6,
    parameter int MAX_ITER = 50
) (
    input  logic [SNR_W-1:0]  snr_idx,
    output logic [ITER_W-1:0] first_check
);

    // Threshold lookup; lower SNR defers checking further.
    always_comb begin
        if (snr_idx < SNR_W'(2))        first_check = ITER_W'(MAX_ITER);
        else if (snr_idx == SNR_W'(2))  first_check = ITER_W'(42);
        else if (snr_idx == SNR_W'(3))  first_check = ITER_W'(10);
        else if (snr_idx == SNR_W'(4))  first_check = ITER_W'(6);
        else if (snr_idx <= SNR_W'(7))  first_check = ITER_W'(4);
        else if (snr_idx == SNR_W'(8))  first_check = ITER_W'(3);
        else if (snr_idx <= SNR_W'(12)) first_check = ITER_W'(2);
        else                            first_check = ITER_W'(1);
    end

endmodule

// File: rtl/ldpc_cap_clamp.sv
// Turns the requested iteration cap into the effective cap:
// zero becomes one, anything above MAX_ITER becomes MAX_ITER.
// Assumes MAX_ITER >= 1.
module ldpc_cap_clamp #(
    parameter int CAP_W    = 6,
    parameter int ITER_W   = 6,
    parameter int MAX_ITER = 50
) (
    input  logic [CAP_W-1:0]  cap_req,
    output logic [ITER_W-1:0] cap_eff
);

    // Clamp into the range 1..MAX_ITER.
    always_comb begin
        if (cap_req == '0)                  cap_eff = ITER_W'(1);
        else if (int'(cap_req) > MAX_ITER)  cap_eff = ITER_W'(MAX_ITER);
        else                                cap_eff = ITER_W'(cap_req);
    end

endmodule

// File: rtl/ldpc_phase_fsm.sv
// Phase sequencer: launches each datapath phase with a registered
// one-cycle enable, waits for its done pulse, counts iterations and
// decides between another iteration, success and giving up.
// Assumes done pulses arrive only for the phase currently launched.
module ldpc_phase_fsm
    import ldpc_ctrl_pkg::*;
#(
    parameter int ITER_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic [ITER_W-1:0] first_check,
    input  logic [ITER_W-1:0] cap_eff,
    input  logic              init_done,
    input  logic              cn_done,
    input  logic              bn_done,
    input  logic              td_done,
    input  logic              pc_done,
    input  logic              syndrome_zero,
    output logic              init_en,
    output logic              cn_en,
    output logic              bn_en,
    output logic              td_en,
    output logic              pc_en,
    output logic              dec_done,
    output logic              dec_ok,
    output logic [ITER_W-1:0] iter_count,
    output logic              busy
);

    phase_e            state_q;
    logic [ITER_W-1:0] iter_q;
    logic [ITER_W-1:0] gate_q;
    logic [ITER_W-1:0] cap_q;
    logic              at_cap;
    logic              gate_open;

    // Current iteration has used up the cap.
    assign at_cap     = (iter_q >= cap_q);
    // Current iteration is late enough to run the decision stages.
    assign gate_open  = (iter_q >= gate_q);
    assign busy       = (state_q != PH_IDLE);
    assign iter_count = iter_q;

    // Phase state, iteration counter, latched settings and enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= PH_IDLE;
            iter_q   <= '0;
            gate_q   <= '0;
            cap_q    <= '0;
            dec_ok   <= 1'b0;
            dec_done <= 1'b0;
            init_en  <= 1'b0;
            cn_en    <= 1'b0;
            bn_en    <= 1'b0;
            td_en    <= 1'b0;
            pc_en    <= 1'b0;
        end else begin
            dec_done <= 1'b0;
            init_en  <= 1'b0;
            cn_en    <= 1'b0;
            bn_en    <= 1'b0;
            td_en    <= 1'b0;
            pc_en    <= 1'b0;
            unique case (state_q)
                PH_IDLE: if (frame_start) begin
                    state_q <= PH_INIT;
                    init_en <= 1'b1;
                    iter_q  <= ITER_W'(1);
                    gate_q  <= first_check;
                    cap_q   <= cap_eff;
                    dec_ok  <= 1'b0;
                end
                PH_INIT: if (init_done) begin
                    state_q <= PH_CN;
                    cn_en   <= 1'b1;
                end
                PH_CN: if (cn_done) begin
                    state_q <= PH_BN;
                    bn_en   <= 1'b1;
                end
                PH_BN: if (bn_done) begin
                    if (gate_open) begin
                        state_q <= PH_TD;
                        td_en   <= 1'b1;
                    end else if (at_cap) begin
                        state_q  <= PH_IDLE;
                        dec_done <= 1'b1;
                    end else begin
                        iter_q  <= iter_q + ITER_W'(1);
                        state_q <= PH_CN;
                        cn_en   <= 1'b1;
                    end
                end
                PH_TD: if (td_done) begin
                    state_q <= PH_PC;
                    pc_en   <= 1'b1;
                end
                PH_PC: if (pc_done) begin
                    if (syndrome_zero || at_cap) begin
                        state_q  <= PH_IDLE;
                        dec_done <= 1'b1;
                        dec_ok   <= syndrome_zero;
                    end else begin
                        iter_q  <= iter_q + ITER_W'(1);
                        state_q <= PH_CN;
                        cn_en   <= 1'b1;
                    end
                end
                default: state_q <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ldpc_iter_ctrl.sv
// Top of the adaptive LDPC iteration controller: SNR-driven gate for
// the decision stages, cap clamp and phase sequencer.
// Assumes the datapath answers every enable with one done pulse.
module ldpc_iter_ctrl #(
    parameter  int MAX_ITER = 50,
    parameter  int SNR_W    = 5,
    parameter  int CAP_W    = 6,
    localparam int ITER_W   = $clog2(MAX_ITER + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic [SNR_W-1:0]  snr_idx,
    input  logic [CAP_W-1:0]  cap_in,
    input  logic              init_done,
    input  logic              cn_done,
    input  logic              bn_done,
    input  logic              td_done,
    input  logic              pc_done,
    input  logic              syndrome_zero,
    output logic              init_en,
    output logic              cn_en,
    output logic              bn_en,
    output logic              td_en,
    output logic              pc_en,
    output logic              dec_done,
    output logic              dec_ok,
    output logic [ITER_W-1:0] iter_count
);

    logic [ITER_W-1:0] first_check;
    logic [ITER_W-1:0] cap_eff;
    logic              busy;

    ldpc_snr_gate #(.SNR_W(SNR_W), .ITER_W(ITER_W), .MAX_ITER(MAX_ITER)) u_gate (
        .snr_idx     (snr_idx),
        .first_check (first_check)
    );

    ldpc_cap_clamp #(.CAP_W(CAP_W), .ITER_W(ITER_W), .MAX_ITER(MAX_ITER)) u_clamp (
        .cap_req (cap_in),
        .cap_eff (cap_eff)
    );

    ldpc_phase_fsm #(.ITER_W(ITER_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_start   (frame_start),
        .first_check   (first_check),
        .cap_eff       (cap_eff),
        .init_done     (init_done),
        .cn_done       (cn_done),
        .bn_done       (bn_done),
        .td_done       (td_done),
        .pc_done       (pc_done),
        .syndrome_zero (syndrome_zero),
        .init_en       (init_en),
        .cn_en         (cn_en),
        .bn_en         (bn_en),
        .td_en         (td_en),
        .pc_en         (pc_en),
        .dec_done      (dec_done),
        .dec_ok        (dec_ok),
        .iter_count    (iter_count),
        .busy          (busy)
    );

endmodule

// File: rtl/ldpc_iter_ctrl_chk.sv
// Property checker for ldpc_iter_ctrl, attached by bind below.
// Assumes the bound instance uses the default-style port names.
module ldpc_iter_ctrl_chk #(
    parameter int ITER_W   = 6,
    parameter int MAX_ITER = 50
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_start,
    input logic              busy,
    input logic              pc_done,
    input logic              syndrome_zero,
    input logic              init_en,
    input logic              cn_en,
    input logic              bn_en,
    input logic              td_en,
    input logic              pc_en,
    input logic              dec_done,
    input logic              dec_ok,
    input logic [ITER_W-1:0] iter_count,
    input logic [ITER_W-1:0] cap_eff
);

    // R2: never two phases launched together
    a_r2_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({init_en, cn_en, bn_en, td_en, pc_en}));

    // R2: an idle frame start launches initialisation next cycle
    a_r2_start_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !busy) |=> init_en);

    // R8: a frame start while busy launches nothing
    a_r8_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && busy) |=> !init_en);

    // R7: end pulse lasts one cycle
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        dec_done |=> !dec_done);

    // R7: results hold while idle until a new frame starts
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !frame_start) |=> ($stable(iter_count) && $stable(dec_ok)));

    // R4: success only follows a zero syndrome report
    a_r4_ok_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dec_ok) |-> $past(pc_done && syndrome_zero));

    // R5: iteration count never exceeds the hard limit
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        iter_count <= ITER_W'(MAX_ITER));

    // R6: effective cap lies in 1..MAX_ITER
    a_r6_cap_range: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_eff != '0) && (cap_eff <= ITER_W'(MAX_ITER)));

endmodule

bind ldpc_iter_ctrl ldpc_iter_ctrl_chk #(.ITER_W(ITER_W), .MAX_ITER(MAX_ITER)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_start   (frame_start),
    .busy          (busy),
    .pc_done       (pc_done),
    .syndrome_zero (syndrome_zero),
    .init_en       (init_en),
    .cn_en         (cn_en),
    .bn_en         (bn_en),
    .td_en         (td_en),
    .pc_en         (pc_en),
    .dec_done      (dec_done),
    .dec_ok        (dec_ok),
    .iter_count    (iter_count),
    .cap_eff       (cap_eff)
);

// File: tb/test_ldpc_iter_ctrl.sv
// Scoreboard bench: run_frame pushes the expected outcome, an emulated
// datapath answers enables, and a monitor compares each end of decoding.
module test_ldpc_iter_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start = 1'b0;
    logic [4:0] snr_idx = '0;
    logic [5:0] cap_in = '0;
    logic       init_done = 1'b0, cn_done = 1'b0, bn_done = 1'b0;
    logic       td_done = 1'b0, pc_done = 1'b0, syndrome_zero = 1'b0;
    logic       init_en, cn_en, bn_en, td_en, pc_en, dec_done, dec_ok;
    logic [5:0] iter_count;

    always #10 clk = ~clk;

    ldpc_iter_ctrl i_ldpc_iter_ctrl (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .snr_idx(snr_idx), .cap_in(cap_in),
        .init_done(init_done), .cn_done(cn_done), .bn_done(bn_done),
        .td_done(td_done), .pc_done(pc_done), .syndrome_zero(syndrome_zero),
        .init_en(init_en), .cn_en(cn_en), .bn_en(bn_en), .td_en(td_en),
        .pc_en(pc_en), .dec_done(dec_done), .dec_ok(dec_ok),
        .iter_count(iter_count)
    );

    typedef struct {
        int    iters;
        int    ok;
        int    tds;
        string tag;
    } exp_t;

    exp_t sb_q[$];
    int   total = 0, bad = 0;
    int   cn_cnt = 0, td_cnt = 0, pc_cnt = 0, init_cnt = 0, order_err = 0;
    int   last_ph = -1, conv_at = 0, lat = 0;
    bit   done_seen = 0;

    task automatic check_eq(string req, string what, int act, int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // R3 threshold as stated in the requirement
    function automatic int first_check(int s);
        if (s < 2) return 50;
        if (s == 2) return 42;
        if (s == 3) return 10;
        if (s == 4) return 6;
        if (s <= 7) return 4;
        if (s == 8) return 3;
        if (s <= 12) return 2;
        return 1;
    endfunction

    // R6 effective cap
    function automatic int eff_cap(int c);
        if (c == 0) return 1;
        if (c > 50) return 50;
        return c;
    endfunction

    // Emulated datapath: answers each enable after lat extra cycles.
    initial begin
        int pend = -1;
        int ph = 0;
        forever begin
            @(negedge clk);
            init_done = 0; cn_done = 0; bn_done = 0; td_done = 0; pc_done = 0;
            syndrome_zero = 0;
            if (pend < 0 && (init_en | cn_en | bn_en | td_en | pc_en)) begin
                if (init_en)     begin ph = 0; if (last_ph != -1) order_err++; init_cnt++; end
                else if (cn_en)  begin ph = 1; if (!(last_ph == 0 || last_ph == 2 || last_ph == 4)) order_err++; cn_cnt++; end
                else if (bn_en)  begin ph = 2; if (last_ph != 1) order_err++; end
                else if (td_en)  begin ph = 3; if (last_ph != 2) order_err++; td_cnt++; end
                else             begin ph = 4; if (last_ph != 3) order_err++; pc_cnt++; end
                last_ph = ph;
                pend = lat;
            end
            if (pend == 0) begin
                case (ph)
                    0: init_done = 1;
                    1: cn_done = 1;
                    2: bn_done = 1;
                    3: td_done = 1;
                    default: begin
                        pc_done = 1;
                        syndrome_zero = (conv_at != 0 && cn_cnt >= conv_at);
                    end
                endcase
                pend = -1;
            end else if (pend > 0) begin
                pend--;
            end
        end
    end

    // Monitor: compares each end of decoding with the scoreboard head.
    initial begin
        forever begin
            @(negedge clk);
            if (dec_done) begin
                if (sb_q.size() == 0) begin
                    check_eq("R7", "unexpected dec_done", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check_eq(e.tag, "iter_count", int'(iter_count), e.iters);
                    check_eq(e.tag, "dec_ok", int'(dec_ok), e.ok);
                    check_eq("R3", "tentative phases", td_cnt, e.tds);
                    check_eq("R3", "parity phases", pc_cnt, e.tds);
                    check_eq("R4", "iterations run", cn_cnt, e.iters);
                end
                done_seen = 1;
            end
        end
    end

    // Runs one frame; disturb injects a stray frame start (R8).
    task automatic run_frame(int snr, int cap, int conv, int l, string tag, bit disturb);
        exp_t e;
        int m, cp, fin, held_it, held_ok;
        m  = first_check(snr);
        cp = eff_cap(cap);
        fin = (conv != 0 && ((conv > m) ? conv : m) <= cp) ? ((conv > m) ? conv : m) : cp;
        e.iters = fin;
        e.ok    = (conv != 0 && ((conv > m) ? conv : m) <= cp) ? 1 : 0;
        e.tds   = (fin >= m) ? fin - m + 1 : 0;
        e.tag   = tag;
        sb_q.push_back(e);
        conv_at = conv; lat = l;
        cn_cnt = 0; td_cnt = 0; pc_cnt = 0; init_cnt = 0; last_ph = -1;
        done_seen = 0;
        @(negedge clk);
        snr_idx = 5'(snr); cap_in = 6'(cap); frame_start = 1;
        @(negedge clk);
        frame_start = 0;
        check_eq("R2", "init_en after start", int'(init_en), 1);
        if (disturb) begin
            repeat (8) @(negedge clk);
            snr_idx = 5'd31; cap_in = 6'd1; frame_start = 1;
            @(negedge clk);
            frame_start = 0;
            check_eq("R8", "init_en after stray start", int'(init_en), 0);
        end
        while (!done_seen) @(negedge clk);
        held_it = int'(iter_count);
        held_ok = int'(dec_ok);
        repeat (3) @(negedge clk);
        check_eq("R7", "dec_done is one cycle", int'(dec_done), 0);
        check_eq("R7", "iter_count held", int'(iter_count), held_it);
        check_eq("R7", "dec_ok held", int'(dec_ok), held_ok);
        check_eq("R2", "phase order errors", order_err, 0);
        if (disturb) check_eq("R8", "init launches", init_cnt, 1);
    endtask

    // Watchdog: a hang counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: quiet during reset
        check_eq("R1", "enables in reset", int'({init_en, cn_en, bn_en, td_en, pc_en}), 0);
        check_eq("R1", "dec_done in reset", int'(dec_done), 0);
        check_eq("R1", "dec_ok in reset", int'(dec_ok), 0);
        check_eq("R1", "iter_count in reset", int'(iter_count), 0);
        rst_n = 1;
        @(negedge clk);
        check_eq("R1", "iter_count after reset", int'(iter_count), 0);

        run_frame(5, 20, 3, 0, "R4", 0);   // converges early, gate at 4
        run_frame(5, 20, 7, 2, "R4", 0);   // converges after gate
        run_frame(13, 10, 1, 0, "R4", 0);  // checks from first iteration
        run_frame(9, 8, 5, 1, "R4", 0);
        run_frame(8, 3, 0, 0, "R5", 0);    // gate at 3 equals cap
        run_frame(4, 6, 0, 0, "R5", 0);
        run_frame(0, 63, 10, 0, "R6", 0);  // oversize cap clamps to 50
        run_frame(0, 63, 0, 0, "R6", 0);
        run_frame(13, 0, 0, 0, "R6", 0);   // zero cap acts as one
        run_frame(3, 5, 2, 0, "R9", 0);    // gate 10 beyond cap 5
        run_frame(2, 45, 0, 0, "R5", 0);
        run_frame(31, 4, 2, 1, "R4", 0);
        run_frame(0, 20, 0, 0, "R8", 1);   // stray start mid-frame

        check_eq("R7", "scoreboard drained", sb_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule